// File: doc/BRIEF.md
# Address monitor wait controller

This block holds the arm, wait and wake state for a user-level monitor/wait instruction pair in one processor core. A monitor request either arms one 64-byte cache line for the user-level flavour or sets up the legacy flavour. A later wait request either enters a low-power wait or falls through at once. While the core waits, the block watches snooped stores, interrupts, exception-class events and a deadline on its own time-stamp counter. It ends the wait with a one-cycle wake pulse that carries a reason code. Execution always resumes after the wait, and the wait is never restarted.

The two monitor flavours exclude each other. Some control-transfer instructions, reported on one strobe, silently cancel a user-level arm. The block does not decode instructions or keep caches coherent: every event comes in as a single-cycle strobe.

Top module: `mon_wait_ctrl`

## Requirements
- R1: While waiting, a valid snooped store whose address bits [47:6] equal the armed line and whose agent ID differs from SELF_AGENT (default 3) ends the wait with reason 1 (monitored store). It also clears both arm flavours, so the next wait falls through.
- R2: A snooped store from agent SELF_AGENT, or to a different line, does not wake the core.
- R3: After the control-transfer strobe (interrupt return, fast system exit or return, privilege-changing far return), a user-level wait falls through.
- R4: A user-level wait falls through when the latest monitor request was a failed user arm (mon_ok_i low), was a legacy monitor, or never happened.
- R5: A legacy wait enters the wait only if the latest monitor request was a legacy monitor. A user arm after it makes the legacy wait fall through.
- R6: An external interrupt ends the wait with reason 2; there is no mask input. The arm stays valid, so a following wait is entered.
- R7: An NMI/SMI strobe ends the wait with reason 3. A debug, machine-check, bus-init, init or reset-class strobe ends it with reason 4. The arm stays valid.
- R8: A user-level wait ends with reason 5 at the first clock edge where the time-stamp counter (0 in the first cycle after reset, then +1 per cycle) is greater than or equal to the deadline latched on entry. Legacy waits never time out.
- R9: When several wake events are present in the same cycle, the lowest reason code is reported.
- R10: A wait that falls through raises wake_o and fall_thru_o for one cycle, with reason 0, in the cycle after the request; waiting_o stays low.
- R11: waiting_o rises in the cycle after an accepted wait request. wake_o lasts one cycle, never coincides with waiting_o, and a woken wait stays ended until a new request. Monitor and cancel strobes take effect for waits requested in later cycles. Events only matter while waiting.
- R12: During reset all outputs are low and no flavour is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_req_i | input | 1 | Monitor request strobe |
| mon_legacy_i | input | 1 | Monitor request is the legacy flavour |
| mon_addr_i | input | AW | Address to monitor |
| mon_ok_i | input | 1 | User arm succeeded |
| wait_req_i | input | 1 | Wait request strobe |
| wait_legacy_i | input | 1 | Wait request is the legacy flavour |
| wait_deadline_i | input | TW | Deadline for a user-level wait |
| xfer_cancel_i | input | 1 | Cancelling control-transfer strobe |
| snoop_vld_i | input | 1 | Snooped store strobe |
| snoop_addr_i | input | AW | Snooped store address |
| snoop_agent_i | input | AGW | Snooped store source agent |
| ext_irq_i | input | 1 | External interrupt strobe |
| nmi_smi_i | input | 1 | NMI or SMI strobe |
| exc_rst_i | input | 1 | Exception or reset-class strobe |
| waiting_o | output | 1 | Core is in the wait |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_reason_o | output | 3 | Wake reason code |
| fall_thru_o | output | 1 | Wait fell through without waiting |

## Verification
The hardest case to reach is a wake where several causes land in the same cycle as the deadline. For that, the core must already be waiting with a deadline only a few counter ticks away. It must also hold a line that the snooped address matches while some other agent issues the store. The bench tracks the counter value cycle by cycle and sets deadlines a few ticks ahead. It draws snoop addresses from two lines and agent IDs from a small range that includes the core's own ID. This makes both coincident events and near misses common in the random phase. Directed cases then force all five wake causes into one cycle, and pair a cancel with a later wait.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  typedef enum logic [2:0] {
    WK_FALL    = 3'd0,
    WK_STORE   = 3'd1,
    WK_IRQ     = 3'd2,
    WK_NMI     = 3'd3,
    WK_EXC     = 3'd4,
    WK_TIMEOUT = 3'd5
  } wake_e;
  localparam int unsigned NUM_EV = 5;
endpackage

// File: rtl/mwc_arm_track.sv
module mwc_arm_track #(
  parameter int unsigned AW       = 48,
  parameter int unsigned LINE_LSB = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mon_req_i,
  input  logic                   mon_legacy_i,
  input  logic [AW-1:0]          mon_addr_i,
  input  logic                   mon_ok_i,
  input  logic                   xfer_cancel_i,
  input  logic                   store_wake_i,
  output logic                   user_arm_o,
  output logic                   leg_arm_o,
  output logic [AW-1:LINE_LSB]   line_o
);
  logic                 user_q, leg_q;
  logic [AW-1:LINE_LSB] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q <= 1'b0;
      leg_q  <= 1'b0;
      line_q <= '0;
    end else if (mon_req_i) begin
      // flavours exclude each other; newest request wins
      line_q <= mon_addr_i[AW-1:LINE_LSB];
      user_q <= !mon_legacy_i && mon_ok_i;
      leg_q  <= mon_legacy_i;
    end else begin
      if (xfer_cancel_i) user_q <= 1'b0;
      if (store_wake_i) begin
        user_q <= 1'b0;
        leg_q  <= 1'b0;
      end
    end
  end

  assign user_arm_o = user_q;
  assign leg_arm_o  = leg_q;
  assign line_o     = line_q;
endmodule

// File: rtl/mwc_tsc.sv
module mwc_tsc #(
  parameter int unsigned TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] deadline_i,
  output logic          expired_o
);
  logic [TW-1:0] tsc_q, dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tsc_q <= '0;
      dl_q  <= '0;
    end else begin
      tsc_q <= tsc_q + 1'b1;
      if (load_i) dl_q <= deadline_i;
    end
  end

  assign expired_o = (tsc_q >= dl_q);
endmodule

// File: rtl/mwc_wake_arb.sv
module mwc_wake_arb
  import mwc_pkg::*;
(
  input  logic [NUM_EV-1:0] ev_i,   // bit k -> reason k+1
  output logic              any_o,
  output wake_e             reason_o
);
  always_comb begin
    reason_o = WK_FALL;
    for (int k = NUM_EV - 1; k >= 0; k--) begin
      if (ev_i[k]) reason_o = wake_e'(3'(k + 1));
    end
  end
  assign any_o = |ev_i;
endmodule

// File: rtl/mon_wait_ctrl.sv
module mon_wait_ctrl
  import mwc_pkg::*;
#(
  parameter int unsigned AW         = 48,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned AGW        = 4,
  parameter int unsigned SELF_AGENT = 3,
  parameter int unsigned TW         = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mon_req_i,
  input  logic           mon_legacy_i,
  input  logic [AW-1:0]  mon_addr_i,
  input  logic           mon_ok_i,
  input  logic           wait_req_i,
  input  logic           wait_legacy_i,
  input  logic [TW-1:0]  wait_deadline_i,
  input  logic           xfer_cancel_i,
  input  logic           snoop_vld_i,
  input  logic [AW-1:0]  snoop_addr_i,
  input  logic [AGW-1:0] snoop_agent_i,
  input  logic           ext_irq_i,
  input  logic           nmi_smi_i,
  input  logic           exc_rst_i,
  output logic           waiting_o,
  output logic           wake_o,
  output logic [2:0]     wake_reason_o,
  output logic           fall_thru_o
);
  localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [AGW-1:0] SELF_ID = AGW'(SELF_AGENT);

  logic                 waiting_q, wleg_q, wake_q, ft_q;
  wake_e                reason_q;
  logic                 user_arm, leg_arm, expired;
  logic [AW-1:LINE_LSB] line;
  logic                 hit, tmo, store_wake, can_wait, enter;
  logic [NUM_EV-1:0]    ev;
  logic                 ev_any;
  wake_e                ev_reason;

  assign hit = snoop_vld_i && (snoop_addr_i[AW-1:LINE_LSB] == line)
               && (snoop_agent_i != SELF_ID);
  assign tmo        = !wleg_q && expired;
  assign ev         = waiting_q ? {tmo, exc_rst_i, nmi_smi_i, ext_irq_i, hit} : '0;
  assign store_wake = ev[0];
  assign can_wait   = wait_legacy_i ? leg_arm : user_arm;
  assign enter      = !waiting_q && wait_req_i && can_wait;

  mwc_arm_track #(.AW(AW), .LINE_LSB(LINE_LSB)) u_arm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mon_req_i     (mon_req_i),
    .mon_legacy_i  (mon_legacy_i),
    .mon_addr_i    (mon_addr_i),
    .mon_ok_i      (mon_ok_i),
    .xfer_cancel_i (xfer_cancel_i),
    .store_wake_i  (store_wake),
    .user_arm_o    (user_arm),
    .leg_arm_o     (leg_arm),
    .line_o        (line)
  );

  mwc_tsc #(.TW(TW)) u_tsc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (enter),
    .deadline_i (wait_deadline_i),
    .expired_o  (expired)
  );

  mwc_wake_arb u_arb (
    .ev_i     (ev),
    .any_o    (ev_any),
    .reason_o (ev_reason)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= 1'b0;
      wleg_q    <= 1'b0;
      wake_q    <= 1'b0;
      ft_q      <= 1'b0;
      reason_q  <= WK_FALL;
    end else begin
      wake_q   <= 1'b0;
      ft_q     <= 1'b0;
      reason_q <= WK_FALL;
      if (waiting_q) begin
        if (ev_any) begin
          waiting_q <= 1'b0;
          wake_q    <= 1'b1;
          reason_q  <= ev_reason;
        end
      end else if (wait_req_i) begin
        if (can_wait) begin
          waiting_q <= 1'b1;
          wleg_q    <= wait_legacy_i;
        end else begin
          wake_q <= 1'b1;
          ft_q   <= 1'b1;
        end
      end
    end
  end

  assign waiting_o     = waiting_q;
  assign wake_o        = wake_q;
  assign wake_reason_o = reason_q;
  assign fall_thru_o   = ft_q;
endmodule

// File: rtl/mon_wait_ctrl_chk.sv
module mon_wait_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       waiting_o,
  input logic       wake_o,
  input logic [2:0] wake_reason_o,
  input logic       fall_thru_o,
  input logic       ext_irq_i,
  input logic       nmi_smi_i,
  input logic       exc_rst_i
);
  p_irq_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o && ext_irq_i |=> wake_o && (wake_reason_o inside {3'd1, 3'd2}));

  p_exc_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o && (nmi_smi_i || exc_rst_i) |=> wake_o && !fall_thru_o
      && wake_reason_o >= 3'd1 && wake_reason_o <= 3'd4);

  p_fall_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_thru_o |-> wake_o && wake_reason_o == 3'd0 && !waiting_o);

  p_wake_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !waiting_o);

  p_wake_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o && !fall_thru_o |-> $past(waiting_o));

  p_code_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> wake_reason_o <= 3'd5);
endmodule

bind mon_wait_ctrl mon_wait_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .waiting_o     (waiting_o),
  .wake_o        (wake_o),
  .wake_reason_o (wake_reason_o),
  .fall_thru_o   (fall_thru_o),
  .ext_irq_i     (ext_irq_i),
  .nmi_smi_i     (nmi_smi_i),
  .exc_rst_i     (exc_rst_i)
);

// File: tb/mon_wait_ctrl_test.sv
module mon_wait_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48, AGW = 4, TW = 64, LSB = 6;
  localparam logic [AGW-1:0] SELF = 4'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mon_req, mon_leg, mon_ok, wait_req, wait_leg, xfer;
  logic snp_vld, irq, nmi, exc;
  logic [AW-1:0]  mon_addr, snp_addr;
  logic [AGW-1:0] snp_agent;
  logic [TW-1:0]  dl;
  logic waiting, wake, ft;
  logic [2:0] rsn;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic m_user, m_leg, m_wait, m_wleg, m_wake, m_ft;
  logic [2:0] m_rsn;
  logic [AW-1:LSB] m_line;
  logic [TW-1:0] m_tsc, m_dl;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_wait_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mon_req_i(mon_req), .mon_legacy_i(mon_leg), .mon_addr_i(mon_addr), .mon_ok_i(mon_ok),
    .wait_req_i(wait_req), .wait_legacy_i(wait_leg), .wait_deadline_i(dl),
    .xfer_cancel_i(xfer), .snoop_vld_i(snp_vld), .snoop_addr_i(snp_addr),
    .snoop_agent_i(snp_agent), .ext_irq_i(irq), .nmi_smi_i(nmi), .exc_rst_i(exc),
    .waiting_o(waiting), .wake_o(wake), .wake_reason_o(rsn), .fall_thru_o(ft)
  );

  function automatic logic [2:0] pick(input logic h, i, n, e, t);
    if (h) return 3'd1;
    if (i) return 3'd2;
    if (n) return 3'd3;
    if (e) return 3'd4;
    if (t) return 3'd5;
    return 3'd0;
  endfunction

  task automatic clr();
    mon_req = 0; mon_leg = 0; mon_ok = 0; wait_req = 0; wait_leg = 0; xfer = 0;
    snp_vld = 0; irq = 0; nmi = 0; exc = 0;
  endtask

  task automatic model();
    logic h, t, sw, ok;
    logic [2:0] r;
    h  = snp_vld && snp_addr[AW-1:LSB] == m_line && snp_agent != SELF;
    t  = !m_wleg && (m_tsc >= m_dl);
    sw = 0;
    m_wake = 0; m_ft = 0; m_rsn = 0;
    if (m_wait) begin
      r = pick(h, irq, nmi, exc, t);
      if (r != 0) begin
        m_wait = 0; m_wake = 1; m_rsn = r; sw = (r == 3'd1);
      end
    end else if (wait_req) begin
      ok = wait_leg ? m_leg : m_user;
      if (ok) begin m_wait = 1; m_wleg = wait_leg; m_dl = dl; end
      else begin m_wake = 1; m_ft = 1; end
    end
    if (mon_req) begin
      m_line = mon_addr[AW-1:LSB];
      m_user = !mon_leg && mon_ok;
      m_leg  = mon_leg;
    end else begin
      if (xfer) m_user = 0;
      if (sw) begin m_user = 0; m_leg = 0; end
    end
    m_tsc = m_tsc + 1;
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (waiting !== m_wait || wake !== m_wake || rsn !== m_rsn || ft !== m_ft) begin
      n_fail++;
      $display("FAIL %s: got wait=%b wake=%b rsn=%0d ft=%b exp wait=%b wake=%b rsn=%0d ft=%b",
               tag, waiting, wake, rsn, ft, m_wait, m_wake, m_rsn, m_ft);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    check(tag);
    clr();
  endtask

  task automatic arm(input logic leg, input logic ok, input logic [AW-1:0] a, input string tag);
    mon_req = 1; mon_leg = leg; mon_ok = ok; mon_addr = a;
    step(tag);
  endtask

  task automatic wt(input logic leg, input int ahead, input string tag);
    wait_req = 1; wait_leg = leg; dl = m_tsc + TW'(ahead);
    step(tag);
  endtask

  localparam logic [AW-1:0] LA = 48'h0000_1234_5640;
  localparam logic [AW-1:0] LB = 48'h0000_1234_5680;

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr(); mon_addr = '0; snp_addr = '0; snp_agent = '0; dl = '0;
    m_user = 0; m_leg = 0; m_wait = 0; m_wleg = 0; m_wake = 0; m_ft = 0; m_rsn = 0;
    m_line = '0; m_tsc = '0; m_dl = '0;
    repeat (3) @(negedge clk);
    check("R12 reset");
    rst_ni = 1;

    wt(0, 100, "R4 unarmed wait");
    // R1 monitored store from another agent, other offset in line
    arm(0, 1, LA, "R1");
    wt(0, 1000, "R1");
    step("R1");
    snp_vld = 1; snp_addr = LA + 48'h1f; snp_agent = 4'd5; step("R1 store wake");
    wt(0, 1000, "R1 arm cleared");
    // R2 own-agent and other-line stores
    arm(0, 1, LA, "R2");
    wt(0, 1000, "R2");
    snp_vld = 1; snp_addr = LA; snp_agent = SELF; step("R2 own agent");
    snp_vld = 1; snp_addr = LB; snp_agent = 4'd1; step("R2 other line");
    irq = 1; step("R6 irq wake");
    wt(0, 1000, "R6 arm kept");
    nmi = 1; step("R7 nmi");
    wt(0, 1000, "R7");
    exc = 1; step("R7 exc");
    // R9 all at once
    wt(0, 0, "R9");
    snp_vld = 1; snp_addr = LA; snp_agent = 4'd0; irq = 1; nmi = 1; exc = 1; step("R9 all");
    arm(0, 1, LA, "R9");
    wt(0, 0, "R9");
    irq = 1; nmi = 1; exc = 1; step("R9 irq first");
    // R8 timeout
    wt(0, 4, "R8");
    for (int i = 0; i < 5; i++) step("R8 timeout");
    // R3 cancel
    xfer = 1; step("R3");
    wt(0, 1000, "R3 cancel falls through");
    // R4 failed arm, legacy monitor
    arm(0, 0, LA, "R4");
    wt(0, 1000, "R4 failed arm");
    arm(1, 0, LA, "R4");
    wt(0, 1000, "R4 legacy mon");
    // R5
    wt(1, 0, "R5 legacy wait");
    for (int i = 0; i < 3; i++) step("R8 legacy no timeout");
    irq = 1; step("R5");
    arm(0, 1, LB, "R5");
    wt(1, 0, "R5 user arm kills legacy");
    // R11 same-cycle arm and wait sees old state
    mon_req = 1; mon_ok = 1; mon_addr = LA; wait_req = 1; dl = m_tsc + 50; step("R11");

    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      mon_req  = (r < 8);
      mon_leg  = ($urandom % 4) == 0;
      mon_ok   = ($urandom % 5) != 0;
      mon_addr = ($urandom % 2) ? LA : LB;
      wait_req = ($urandom % 4) == 0;
      wait_leg = ($urandom % 5) == 0;
      dl       = m_tsc + TW'($urandom % 12);
      xfer     = ($urandom % 25) == 0;
      snp_vld  = ($urandom % 6) == 0;
      snp_addr = (($urandom % 2) ? LA : LB) + AW'($urandom % 64);
      snp_agent = AGW'($urandom % 5);
      irq = ($urandom % 30) == 0;
      nmi = ($urandom % 40) == 0;
      exc = ($urandom % 40) == 0;
      step("R11 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
  end
endmodule